// File: doc/BRIEF.md
# Timestamp Capture Slot Bank

This block records the free-running 64-bit nanosecond time at the moment a qualifying packet event is flagged. The receive side has a bank of capture slots. The transmit side has one slot. Packet classification happens upstream, so each side sees only a one-cycle event strobe. When a receive capture lands, the block reports which slot it used. That index can then travel with the packet, and software uses it later to fetch the matching timestamp.

Each slot is read as two 32-bit halves through a small read port. Reading the low half returns the low 32 bits and snapshots the upper 32 bits, so the 64-bit read is coherent. Reading the high half returns that snapshot and frees the slot. A slot that is never freed keeps its value for good. If every receive slot stays occupied, later receive events are dropped and a sticky overflow flag is raised. Software recovers by reading the high half of every slot. The transmit slot can raise a level interrupt while it holds a value, gated by an enable input.

Top module: `tstamp_slot_bank`

## Requirements
- R1: After reset, all slot-valid bits are 0 and `tx_irq`, `rx_ovf`, `rx_cap_ok` and `rd_data` are all 0.
- R2: A receive event in a cycle with a free slot stores `cur_time` from that clock edge into the lowest-numbered free slot. On the following cycle `rx_cap_ok` is 1 for one cycle and `rx_cap_idx` gives that slot number.
- R3: An occupied slot keeps its stored value and stays valid across any number of further events until its high half is read.
- R4: A read with `rd_hi`=0 returns bits 31:0 of the selected slot and snapshots bits 63:32. A following read with `rd_hi`=1 returns the snapshot and clears that slot's valid bit. Read data appears on the cycle after `rd_en`.
- R5: A low-half read does not free the slot.
- R6: A receive event that arrives while every receive slot is occupied is dropped: no slot changes and `rx_cap_ok` stays 0. It also sets `rx_ovf`, which stays 1 until reset.
- R7: Reading the high half of every receive slot empties the bank, and the next receive event lands in slot 0.
- R8: A transmit event while the transmit slot is free captures `cur_time` and sets `tx_valid`. Transmit events that arrive while the slot is occupied are ignored.
- R9: `tx_irq` is 1 exactly when the transmit slot is valid and `tx_irq_en` is 1.
- R10: `rd_sel` values 0 to RX_SLOTS-1 select receive slots and RX_SLOTS selects the transmit slot. Higher values read 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_time | input | 64 | Current time in nanoseconds |
| rx_event | input | 1 | Receive capture strobe |
| tx_event | input | 1 | Transmit capture strobe |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Slot select (receive slots, then transmit) |
| rd_hi | input | 1 | 0 reads the low half, 1 reads the high half and frees the slot |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| rx_cap_ok | output | 1 | Receive capture done, one-cycle pulse |
| rx_cap_idx | output | 2 | Slot used by that capture |
| rx_valid | output | 4 | Per-slot occupied bits, bit n for slot n |
| rx_ovf | output | 1 | Sticky dropped-event flag |
| tx_valid | output | 1 | Transmit slot occupied |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bench builds the block with its defaults: four receive slots, 64-bit time and 32-bit read words. With only four receive slots, filling the bank and overflowing it takes just a few events. Every single-slot release position can be swept, and so can an out-of-order two-slot release. The lowest-free-first rule and the drop behaviour are therefore checked against an arithmetic model of which slots are occupied. Every expected time word is computed from the slot or step number.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
   typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tsb_slot.sv
module tsb_slot #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              rel,
   input  logic [TIME_W-1:0] time_in,
   output logic              valid,
   output logic [TIME_W-1:0] value
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         value <= '0;
      end else if (cap && !valid) begin
         valid <= 1'b1;
         value <= time_in;
      end else if (rel) begin
         valid <= 1'b0;
      end
   end

   // R3
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !rel |=> valid && $stable(value));
endmodule

// File: rtl/tsb_pick.sv
module tsb_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     busy,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] grant_idx,
   output logic             full
);
   logic found;

   always_comb begin
      grant     = '0;
      grant_idx = '0;
      found     = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (!busy[i] && !found) begin
            grant[i]  = 1'b1;
            grant_idx = IDX_W'(i);
            found     = 1'b1;
         end
      end
      full = &busy;
   end
endmodule

// File: rtl/tstamp_slot_bank.sv
module tstamp_slot_bank #(
   parameter int TIME_W   = 64,
   parameter int REG_W    = 32,
   parameter int RX_SLOTS = 4,
   parameter int IDX_W    = tsb_pkg::idx_width(RX_SLOTS),
   parameter int SEL_W    = tsb_pkg::idx_width(RX_SLOTS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [TIME_W-1:0]   cur_time,
   input  logic                rx_event,
   input  logic                tx_event,
   input  logic                tx_irq_en,
   input  logic                rd_en,
   input  logic [SEL_W-1:0]    rd_sel,
   input  logic                rd_hi,
   output logic [REG_W-1:0]    rd_data,
   output logic                rx_cap_ok,
   output logic [IDX_W-1:0]    rx_cap_idx,
   output logic [RX_SLOTS-1:0] rx_valid,
   output logic                rx_ovf,
   output logic                tx_valid,
   output logic                tx_irq
);
   import tsb_pkg::*;

   localparam int NSLOT = RX_SLOTS + 1;
   localparam int TX_ID = RX_SLOTS;
   localparam int HI_W  = TIME_W - REG_W;

   if (TIME_W != 2 * REG_W) begin : g_bad_width
      $error("TIME_W must be twice REG_W");
   end
   if (RX_SLOTS < 1) begin : g_bad_slots
      $error("RX_SLOTS must be at least 1");
   end

   logic [NSLOT-1:0]    slot_valid;
   logic [NSLOT-1:0]    slot_cap;
   logic [NSLOT-1:0]    slot_rel;
   logic [TIME_W-1:0]   slot_val [NSLOT];
   logic [RX_SLOTS-1:0] rx_grant;
   logic [IDX_W-1:0]    rx_gidx;
   logic                rx_full;
   logic [HI_W-1:0]     hi_shadow;
   logic                sel_ok;
   half_e               half;

   assign rx_valid = slot_valid[RX_SLOTS-1:0];
   assign tx_valid = slot_valid[TX_ID];
   assign tx_irq   = slot_valid[TX_ID] & tx_irq_en;
   assign sel_ok   = (rd_sel < SEL_W'(NSLOT));
   assign half     = half_e'(rd_hi);

   tsb_pick #(.N(RX_SLOTS), .IDX_W(IDX_W)) u_pick (
      .busy      (slot_valid[RX_SLOTS-1:0]),
      .grant     (rx_grant),
      .grant_idx (rx_gidx),
      .full      (rx_full)
   );

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i < RX_SLOTS) begin : g_rx
         assign slot_cap[i] = rx_event & rx_grant[i];
      end else begin : g_tx
         assign slot_cap[i] = tx_event;
      end
      assign slot_rel[i] = rd_en && (half == HALF_HI) && (rd_sel == SEL_W'(i));

      tsb_slot #(.TIME_W(TIME_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .cap     (slot_cap[i]),
         .rel     (slot_rel[i]),
         .time_in (cur_time),
         .valid   (slot_valid[i]),
         .value   (slot_val[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data    <= '0;
         hi_shadow  <= '0;
         rx_cap_ok  <= 1'b0;
         rx_cap_idx <= '0;
         rx_ovf     <= 1'b0;
      end else begin
         rx_cap_ok  <= rx_event && !rx_full;
         rx_cap_idx <= rx_gidx;
         if (rx_event && rx_full) rx_ovf <= 1'b1;
         if (rd_en) begin
            if (!sel_ok) begin
               rd_data <= '0;
            end else if (half == HALF_LO) begin
               rd_data   <= slot_val[rd_sel][REG_W-1:0];
               hi_shadow <= slot_val[rd_sel][TIME_W-1:REG_W];
            end else begin
               rd_data <= hi_shadow;
            end
         end
      end
   end

   // R2
   rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event && !rx_full |=> rx_cap_ok && rx_valid[rx_cap_idx]);
   // R6
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event && rx_full |=> !rx_cap_ok && rx_ovf);
   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> rx_ovf);
   // R4
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_hi && sel_ok |=> !slot_valid[$past(rd_sel)]);
   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_grant));
endmodule

// File: tb/tb_tstamp_slot_bank.sv
module tb_tstamp_slot_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] cur_time;
   logic        rx_event, tx_event, tx_irq_en, rd_en, rd_hi;
   logic [2:0]  rd_sel;
   logic [31:0] rd_data;
   logic        rx_cap_ok, rx_ovf, tx_valid, tx_irq;
   logic [1:0]  rx_cap_idx;
   logic [3:0]  rx_valid;

   int checks = 0;
   int errors = 0;
   logic [63:0] exp_rx [4];
   logic [3:0]  model_busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   tstamp_slot_bank dut (
      .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .rx_event(rx_event),
      .tx_event(tx_event), .tx_irq_en(tx_irq_en), .rd_en(rd_en),
      .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data),
      .rx_cap_ok(rx_cap_ok), .rx_cap_idx(rx_cap_idx), .rx_valid(rx_valid),
      .rx_ovf(rx_ovf), .tx_valid(tx_valid), .tx_irq(tx_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [63:0] stamp(input int n);
      return {32'hC0DE_0000 + 32'(n), 32'h0100_0000 * 32'(n + 1) + 32'd7};
   endfunction

   function automatic int lowest_free(input logic [3:0] b);
      for (int i = 0; i < 4; i++) if (!b[i]) return i;
      return -1;
   endfunction

   task automatic rx_ev(input logic [63:0] t, input string req);
      int want;
      want = lowest_free(model_busy);
      cur_time = t;
      rx_event = 1'b1;
      tick();
      rx_event = 1'b0;
      if (want < 0) begin
         chk({req, " drop cap_ok"}, rx_cap_ok, 0);
         chk({req, " ovf set"}, rx_ovf, 1);
      end else begin
         chk({req, " cap_ok"}, rx_cap_ok, 1);
         chk({req, " idx"}, rx_cap_idx, want);
         model_busy[want] = 1'b1;
         exp_rx[want] = t;
      end
      chk({req, " valid"}, rx_valid, model_busy);
   endtask

   task automatic rd(input int sel, input logic hi, output logic [31:0] d);
      rd_sel = 3'(sel);
      rd_hi  = hi;
      rd_en  = 1'b1;
      tick();
      rd_en  = 1'b0;
      d = rd_data;
   endtask

   task automatic rd_full(input int sel, input logic [63:0] expv, input string req);
      logic [31:0] d;
      rd(sel, 1'b0, d);
      chk({req, " low word"}, d, expv[31:0]);
      rd(sel, 1'b1, d);
      chk({req, " high word"}, d, expv[63:32]);
      if (sel < 4) model_busy[sel] = 1'b0;
      chk({req, " released"}, {tx_valid, rx_valid}, {(sel == 4) ? 1'b0 : tx_valid, model_busy});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; cur_time = '0; rx_event = 0; tx_event = 0; tx_irq_en = 0;
      rd_en = 0; rd_hi = 0; rd_sel = '0; model_busy = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 valid", {tx_valid, rx_valid}, 0);
      chk("R1 flags", {tx_irq, rx_ovf, rx_cap_ok}, 0);
      chk("R1 rd_data", rd_data, 0);

      // R2 fill in order
      for (int k = 0; k < 4; k++) rx_ev(stamp(k), "R2 fill");
      // R6 overflow, R3 hold
      rx_ev(stamp(50), "R6 full");
      rx_ev(stamp(51), "R6 full again");
      // R5 low reads do not free; R3 values intact
      for (int k = 0; k < 4; k++) begin
         rd(k, 1'b0, d);
         chk("R3 R5 low word held", d, exp_rx[k][31:0]);
         chk("R5 still valid", rx_valid, 4'hF);
      end
      // R2 sweep of release position
      for (int k = 0; k < 4; k++) begin
         rd_full(k, exp_rx[k], "R4 release");
         rx_ev(stamp(10 + k), "R2 refill lowest");
         chk("R2 refill slot", rx_cap_idx, k);
      end
      // R2 two free slots, out of order release
      rd_full(3, exp_rx[3], "R4 release 3");
      rd_full(1, exp_rx[1], "R4 release 1");
      rx_ev(stamp(20), "R2 two free first");
      chk("R2 picks 1", rx_cap_idx, 1);
      rx_ev(stamp(21), "R2 two free second");
      chk("R2 picks 3", rx_cap_idx, 3);
      rd(1, 1'b0, d);
      chk("R4 refill value", d, stamp(20) & 64'hFFFF_FFFF);
      // R7 recovery by high reads only
      for (int k = 0; k < 4; k++) rd(k, 1'b1, d);
      model_busy = '0;
      chk("R7 bank empty", rx_valid, 0);
      rx_ev(stamp(30), "R7 after recovery");
      chk("R7 lands in 0", rx_cap_idx, 0);
      chk("R6 ovf sticky", rx_ovf, 1);

      // R8 / R9 transmit slot
      cur_time = stamp(40);
      tx_event = 1'b1;
      tick();
      tx_event = 1'b0;
      chk("R8 tx valid", tx_valid, 1);
      chk("R9 irq gated off", tx_irq, 0);
      tx_irq_en = 1'b1;
      #1;
      chk("R9 irq on", tx_irq, 1);
      cur_time = stamp(41);
      tx_event = 1'b1;
      tick();
      tx_event = 1'b0;
      // R10 select 4 is the transmit slot
      rd_full(4, stamp(40), "R8 R10 tx held");
      chk("R9 irq clears", tx_irq, 0);
      chk("R8 tx freed", tx_valid, 0);
      // R10 out-of-range select
      rd(6, 1'b1, d);
      chk("R10 bad sel data", d, 0);
      chk("R10 bad sel no effect", rx_valid, 4'b0001);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule